// File: doc/BRIEF.md
# Display RAM host access port

This block is the host-side register port of a graphics LCD controller's on-chip display RAM. A host selects one of a few internal registers with a 3-bit index and strobes either a write or a read over an 8-bit data bus. Two position registers (a 6-bit column position and a 7-bit row position) form the RAM address. A data register gives the host direct access to the RAM contents.

Writing the data register stores the bus byte into the RAM at once. Reading it goes through a one-deep fetch latch. Each data read returns the byte fetched by the previous data read, then loads the byte at the current address into the latch. Every data access, read or write, moves the address by one step along the axis chosen in a mode register. The host can therefore stream a whole row or column without rewriting the address. After any accepted address write, the first data read is a dummy read.

Top module: `dram_host_port`

## Requirements
- R1: After reset, rdata is 0x00, both positions are 0, the step mode is 0 and the fetch latch holds 0x00.
- R2: A write to index 2 loads the column position from bus bits 5..0. A read of index 2 returns the column position in bits 5..0, with bits 7..6 as 0.
- R3: A write to index 3 with a value from 0x00 to 0x40 loads the row position. A larger value is dropped, and the position and latch keep their values. A read of index 3 returns the row position, with bit 7 always 0.
- R4: A write to index 4 stores the bus byte in RAM at linear address row*64 + column.
- R5: A read of index 4 puts the current latch byte on rdata. In the same cycle it loads the latch with the RAM byte at the current address, so each data read returns the byte fetched by the read before it.
- R6: An accepted write to index 2 or index 3 clears the latch to 0x00. The dummy read that follows returns 0x00.
- R7: With step mode 0, every data access raises the row position by one, wrapping from 0x40 to 0x00, and leaves the column unchanged.
- R8: With step mode 1, every data access raises the column position by one, wrapping from 63 to 0, and leaves the row unchanged.
- R9: Bit 0 of index 1 holds the step mode. A read of index 1 returns the step mode in bit 0, with all other bits 0.
- R10: Writes and reads to indices 0, 5, 6 and 7 change no state, and rdata keeps its previous value. rdata changes only on a read of index 1 to 4.
- R11: When write and read strobes are high in the same cycle, only the write takes effect. rdata, the latch and the address see no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register index |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |

## Verification
The write and read strobes can arrive in the same cycle. The bench raises both together on the data index and on the column index. It then judges the result through later reads: the written byte and the new position must appear, rdata must not have moved, and the address must have stepped exactly once. The bench also hits the row limit and both wrap points while accesses stream through them, because the step and the limit check act on the same position register.

// File: rtl/dram_host_pkg.sv
package dram_host_pkg;

    // Register indices seen on the select bus
    localparam logic [2:0] SEL_MODE = 3'd1;
    localparam logic [2:0] SEL_XPOS = 3'd2;
    localparam logic [2:0] SEL_YPOS = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;

    // Decoded one-cycle access strobes
    typedef struct packed {
        logic mode_wr;
        logic xpos_wr;
        logic ypos_wr;
        logic data_wr;
        logic mode_rd;
        logic xpos_rd;
        logic ypos_rd;
        logic data_rd;
    } host_strb_t;

endpackage

// File: rtl/dram_host_decode.sv
module dram_host_decode
    import dram_host_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       wr_en,
    input  logic       rd_en,
    output host_strb_t strb
);

    logic rd_ok;

    always_comb begin
        // a write strobe masks a read strobe of the same cycle
        rd_ok = rd_en & ~wr_en;
        strb  = '0;
        unique case (sel)
            SEL_MODE: begin
                strb.mode_wr = wr_en;
                strb.mode_rd = rd_ok;
            end
            SEL_XPOS: begin
                strb.xpos_wr = wr_en;
                strb.xpos_rd = rd_ok;
            end
            SEL_YPOS: begin
                strb.ypos_wr = wr_en;
                strb.ypos_rd = rd_ok;
            end
            SEL_DATA: begin
                strb.data_wr = wr_en;
                strb.data_rd = rd_ok;
            end
            default: strb = '0;
        endcase
    end

endmodule

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl #(
    parameter int DATA_W = 8,
    parameter int X_BITS = 6,
    parameter int Y_MAX  = 64,
    localparam int Y_BITS = $clog2(Y_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              xpos_wr,
    input  logic              ypos_wr,
    input  logic              data_acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              step_x,
    output logic [X_BITS-1:0] x_pos,
    output logic [Y_BITS-1:0] y_pos,
    output logic              addr_load
);

    typedef struct packed {
        logic              step_x;
        logic [X_BITS-1:0] x;
        logic [Y_BITS-1:0] y;
    } pos_state_t;

    pos_state_t st_d, st_q;
    logic       y_ok;

    always_comb begin
        st_d      = st_q;
        y_ok      = (wdata <= DATA_W'(Y_MAX));
        addr_load = xpos_wr | (ypos_wr & y_ok);

        if (mode_wr) begin
            st_d.step_x = wdata[0];
        end
        if (xpos_wr) begin
            st_d.x = wdata[X_BITS-1:0];
        end
        if (ypos_wr && y_ok) begin
            st_d.y = wdata[Y_BITS-1:0];
        end
        if (data_acc) begin
            if (st_q.step_x) begin
                st_d.x = st_q.x + X_BITS'(1);
            end else if (st_q.y == Y_BITS'(Y_MAX)) begin
                st_d.y = '0;
            end else begin
                st_d.y = st_q.y + Y_BITS'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_x = st_q.step_x;
    assign x_pos  = st_q.x;
    assign y_pos  = st_q.y;

    // R3: the row position never leaves its legal range
    p_y_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.y <= Y_BITS'(Y_MAX));

    // R3: an out-of-range row write leaves the row untouched
    p_y_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ypos_wr && (wdata > DATA_W'(Y_MAX))) |=> $stable(st_q.y));

    // R7: row stepping leaves the column alone
    p_x_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !st_q.step_x && !xpos_wr) |=> $stable(st_q.x));

    // R8: column stepping leaves the row alone
    p_y_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && st_q.step_x && !ypos_wr) |=> $stable(st_q.y));

endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int DATA_W = 8,
    parameter int A_BITS = 13,
    parameter int DEPTH  = 4160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic              clr,
    input  logic [A_BITS-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] latch_d, latch_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        latch_d = latch_q;
        if (clr) begin
            latch_d = '0;
        end else if (re) begin
            latch_d = mem[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    assign latch = latch_q;

    // R6: an accepted address write empties the fetch latch
    p_latch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (latch_q == '0));

    // R4: every RAM access lands inside the populated range
    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we || re) |-> (int'(addr) < DEPTH));

endmodule

// File: rtl/dram_host_port.sv
module dram_host_port
    import dram_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int X_BITS = 6,
    parameter int Y_MAX  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int Y_BITS  = $clog2(Y_MAX + 1);
    localparam int A_BITS  = Y_BITS + X_BITS;
    localparam int X_COUNT = 1 << X_BITS;
    localparam int DEPTH   = X_COUNT * (Y_MAX + 1);

    host_strb_t        strb;
    logic              step_x;
    logic [X_BITS-1:0] x_pos;
    logic [Y_BITS-1:0] y_pos;
    logic              addr_load;
    logic [DATA_W-1:0] latch;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              any_rd;

    dram_host_decode i_decode (
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .strb  (strb)
    );

    dram_addr_ctrl #(
        .DATA_W (DATA_W),
        .X_BITS (X_BITS),
        .Y_MAX  (Y_MAX)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (strb.mode_wr),
        .xpos_wr   (strb.xpos_wr),
        .ypos_wr   (strb.ypos_wr),
        .data_acc  (strb.data_wr | strb.data_rd),
        .wdata     (wdata),
        .step_x    (step_x),
        .x_pos     (x_pos),
        .y_pos     (y_pos),
        .addr_load (addr_load)
    );

    dram_store #(
        .DATA_W (DATA_W),
        .A_BITS (A_BITS),
        .DEPTH  (DEPTH)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strb.data_wr),
        .re    (strb.data_rd),
        .clr   (addr_load),
        .addr  ({y_pos, x_pos}),
        .wdata (wdata),
        .latch (latch)
    );

    always_comb begin
        any_rd  = strb.mode_rd | strb.xpos_rd | strb.ypos_rd | strb.data_rd;
        rdata_d = rdata_q;
        if (strb.mode_rd) begin
            rdata_d = DATA_W'(step_x);
        end else if (strb.xpos_rd) begin
            rdata_d = DATA_W'(x_pos);
        end else if (strb.ypos_rd) begin
            rdata_d = DATA_W'(y_pos);
        end else if (strb.data_rd) begin
            rdata_d = latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R10: the read bus moves only on a read of an implemented index
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> $stable(rdata_q));

    // R11: at most one access acts in any cycle
    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

endmodule

// File: tb/test_dram_host_port.sv
module test_dram_host_port;

    localparam int CLK_PERIOD = 10;
    localparam int Y_MAX      = 64;
    localparam int X_COUNT    = 64;
    localparam int DEPTH      = X_COUNT * (Y_MAX + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side model built from the requirements
    logic [7:0] m_mem [DEPTH];
    logic [5:0] m_x     = '0;
    logic [6:0] m_y     = '0;
    logic       m_inc   = 1'b0;
    logic [7:0] m_latch = '0;
    logic [7:0] m_rdata = '0;

    dram_host_port i_dram_host_port (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(int x, int y);
        return 8'(((x * 37) + (y * 11) + 5) ^ 8'h3C);
    endfunction

    function automatic int lin(logic [6:0] y, logic [5:0] x);
        return int'(y) * X_COUNT + int'(x);
    endfunction

    task automatic m_step();
        if (m_inc) m_x = m_x + 6'd1;
        else m_y = (m_y == 7'(Y_MAX)) ? 7'd0 : m_y + 7'd1;
    endtask

    task automatic m_write(input logic [2:0] idx, input logic [7:0] d);
        case (idx)
            3'd1: m_inc = d[0];
            3'd2: begin m_x = d[5:0]; m_latch = 8'h00; end
            3'd3: if (d <= 8'(Y_MAX)) begin m_y = d[6:0]; m_latch = 8'h00; end
            3'd4: begin m_mem[lin(m_y, m_x)] = d; m_step(); end
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        sel = idx; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(idx, d);
    endtask

    task automatic host_rd(input logic [2:0] idx, input string req);
        @(negedge clk);
        sel = idx; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        case (idx)
            3'd1: m_rdata = {7'd0, m_inc};
            3'd2: m_rdata = {2'd0, m_x};
            3'd3: m_rdata = {1'b0, m_y};
            3'd4: begin
                m_rdata = m_latch;
                m_latch = m_mem[lin(m_y, m_x)];
                m_step();
            end
            default: ;
        endcase
        chk(req, rdata, m_rdata);
    endtask

    task automatic host_both(input logic [2:0] idx, input logic [7:0] d, input string req);
        @(negedge clk);
        sel = idx; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        m_write(idx, d);
        chk(req, rdata, m_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", rdata, 8'h00);
        host_rd(3'd1, "R1");
        host_rd(3'd2, "R1");
        host_rd(3'd3, "R1");
        host_rd(3'd4, "R1");

        // R9: step mode bit
        host_wr(3'd1, 8'hFF);
        host_rd(3'd1, "R9");
        host_wr(3'd1, 8'hFE);
        host_rd(3'd1, "R9");

        // R2: column register sweep
        for (int v = 0; v < 256; v++) begin
            host_wr(3'd2, 8'(v));
            host_rd(3'd2, "R2");
        end

        // R3: row register sweep with limit
        for (int v = 0; v < 256; v++) begin
            host_wr(3'd3, 8'(v));
            host_rd(3'd3, "R3");
        end

        // R4 / R7: fill every location with row stepping
        host_wr(3'd1, 8'h00);
        for (int x = 0; x < X_COUNT; x++) begin
            host_wr(3'd2, 8'(x));
            host_wr(3'd3, 8'h00);
            for (int y = 0; y <= Y_MAX; y++) host_wr(3'd4, pat(x, y));
            host_rd(3'd3, "R7");
            host_rd(3'd2, "R7");
        end

        // R4 / R5 / R6: read every location back
        for (int x = 0; x < X_COUNT; x++) begin
            host_wr(3'd2, 8'(x));
            host_wr(3'd3, 8'h00);
            host_rd(3'd4, "R6");
            for (int y = 0; y <= Y_MAX; y++) begin
                host_rd(3'd4, "R4");
                chk("R5", rdata, pat(x, y));
            end
        end

        // R8: column stepping with wrap
        host_wr(3'd1, 8'h01);
        host_wr(3'd3, 8'd5);
        host_wr(3'd2, 8'd60);
        for (int k = 0; k < 6; k++) host_wr(3'd4, 8'hC0 + 8'(k));
        host_rd(3'd2, "R8");
        host_rd(3'd3, "R8");
        host_wr(3'd2, 8'd60);
        host_rd(3'd4, "R6");
        for (int k = 0; k < 6; k++) begin
            host_rd(3'd4, "R8");
            chk("R8", rdata, 8'hC0 + 8'(k));
        end

        // R3 / R5: rejected row write keeps the latch
        host_wr(3'd1, 8'h00);
        host_wr(3'd2, 8'd7);
        host_wr(3'd3, 8'd9);
        host_rd(3'd4, "R6");
        host_wr(3'd3, 8'd200);
        host_rd(3'd4, "R3");
        chk("R5", rdata, pat(7, 9));
        host_rd(3'd3, "R3");

        // R10: unimplemented indices
        for (int i = 0; i < 8; i++) begin
            if (i == 0 || i > 4) begin
                host_wr(3'(i), 8'h96);
                host_rd(3'(i), "R10");
            end
        end
        host_rd(3'd1, "R10");
        host_rd(3'd2, "R10");
        host_rd(3'd3, "R10");
        host_rd(3'd4, "R10");

        // R11: both strobes at once
        host_wr(3'd2, 8'd10);
        host_wr(3'd3, 8'd20);
        host_both(3'd4, 8'hE7, "R11");
        host_rd(3'd3, "R11");
        host_both(3'd2, 8'd33, "R11");
        host_rd(3'd2, "R11");
        host_wr(3'd2, 8'd10);
        host_wr(3'd3, 8'd20);
        host_rd(3'd4, "R11");
        host_rd(3'd4, "R11");
        chk("R11", rdata, 8'hE7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule